// File: doc/BRIEF.md
# Grouped Look-Ahead Program Counter

This block holds the address of the next instruction and moves it up by one each time an advance request arrives. The address is 15 bits wide, which covers 32768 words. A plain counter would pass its carry from bit to bit through all fifteen positions. This one splits the positions into five groups of three instead. A group steps whenever every position below it holds a one, and that test is made directly from the stored bits. A group therefore switches on the same clock as the lowest bit and never waits for the group below it to settle.

The counter can also be loaded from an address bus in parallel, for example with a branch target. A load wins over a step presented in the same cycle. An extra wrap flag sits above the address. It is set when the address rolls from all ones to zero, but only while the storage-clear mode input is high. A clear sweep uses this flag to learn that it has visited every location. Outside that mode a rollover leaves the flag as it was.

Top module: `grp_pc`

## Requirements
- R1: With `rst` high at a rising clock edge, `addr` becomes 0 and `wrap` becomes 0.
- R2: With `load` high, at the next edge `addr` takes the value on `load_addr` and `wrap` keeps its value. This holds whether or not `step` is high.
- R3: With `step` high and `load` low, at the next edge `addr` becomes the old `addr` plus 1, modulo 2^ADDR_W. Every bit that changes does so on that same edge.
- R4: A group of three bits advances exactly when `step` is high and every bit below it is one. When it advances, its lower groups all become zero.
- R5: With neither `step` nor `load` high, `addr` and `wrap` hold their values.
- R6: A step taken while `addr` is all ones and `clr_mode` is high gives `addr` = 0 and sets `wrap` to 1.
- R7: A step taken while `addr` is all ones and `clr_mode` is low gives `addr` = 0 and leaves `wrap` unchanged. `wrap` never changes except through `rst` or the case in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; clears the address and the wrap flag |
| step | input | 1 | Advance the address by one |
| load | input | 1 | Parallel load of the address; takes priority over step |
| load_addr | input | ADDR_W | Value used by a load |
| clr_mode | input | 1 | Storage-clear sweep mode; allows the wrap flag to be set |
| addr | output | ADDR_W | Current instruction address |
| wrap | output | 1 | Set when the address wraps during a clear sweep |

## Verification
The hardest cases to reach are the wide carries, such as 0x0FFF to 0x1000 and 0x7FFF to 0x0000. Reaching them by stepping from zero takes tens of thousands of cycles. The bench loads a value just below each group boundary and then steps across the boundary. A separate scenario starts from zero and steps the counter through the whole 32768-word space in clear mode. At every step it checks the counter against a +1 model, and it checks that `wrap` rises only on the final step.

// File: rtl/grp_pc.sv
module grp_pc #(
  parameter int ADDR_W = 15,
  parameter int GRP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              clr_mode,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap
);
  localparam int NGRP = (ADDR_W + GRP_W - 1) / GRP_W;

  logic [ADDR_W-1:0] nxt;
  logic [NGRP-1:0]   grp_go;
  logic              all_ones;

  assign all_ones = &addr;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = g * GRP_W;
    localparam int HI = (LO + GRP_W > ADDR_W) ? ADDR_W - 1 : LO + GRP_W - 1;
    localparam int W  = HI - LO + 1;
    if (g == 0) begin : g_first
      assign grp_go[g] = step;
    end else begin : g_rest
      assign grp_go[g] = step & (&addr[LO-1:0]);
    end
    logic [W-1:0] seg;
    assign seg = addr[HI:LO];
    assign nxt[HI:LO] = grp_go[g] ? seg + W'(1) : seg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      wrap <= 1'b0;
    end else if (load) begin
      addr <= load_addr;
    end else if (step) begin
      addr <= nxt;
      if (all_ones && clr_mode) wrap <= 1'b1;
    end
  end

  a_r1_reset: assert property (@(posedge clk) rst |=> (addr == '0 && !wrap));
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(load_addr) && wrap == $past(wrap)));
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> addr == ADDR_W'($past(addr) + 1'b1));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> ($stable(addr) && $stable(wrap)));
  a_r6_wrap_set: assert property (@(posedge clk) disable iff (rst)
    (step && !load && clr_mode && all_ones) |=> wrap);
  a_r7_wrap_only: assert property (@(posedge clk) disable iff (rst)
    !(step && !load && clr_mode && all_ones) |=> wrap == $past(wrap));
  a_r4_group: assert property (@(posedge clk) disable iff (rst)
    (step && !load && addr[GRP_W-1:0] != {GRP_W{1'b1}}) |=> addr[ADDR_W-1:GRP_W] == $past(addr[ADDR_W-1:GRP_W]));
endmodule

// File: tb/sim_grp_pc.sv
module sim_grp_pc;
  logic clk = 0, rst = 1, step = 0, load = 0, clr_mode = 0;
  logic [14:0] load_addr = '0;
  logic [14:0] addr;
  logic wrap;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  grp_pc u0 (.clk(clk), .rst(rst), .step(step), .load(load), .load_addr(load_addr),
             .clr_mode(clr_mode), .addr(addr), .wrap(wrap));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic l, logic [14:0] la, logic cm);
    step = s; load = l; load_addr = la; clr_mode = cm;
    @(posedge clk); #5;
    step = 0; load = 0;
  endtask

  task automatic t_reset;
    rst = 1; @(posedge clk); #5; rst = 0;
    chk("R1 addr", {1'b0, addr}, 16'h0);
    chk("R1 wrap", {15'b0, wrap}, 16'h0);
  endtask

  task automatic t_load;
    cyc(0, 1, 15'h1234, 0); chk("R2 load", {wrap, addr}, 16'h1234);
    cyc(1, 1, 15'h0555, 0); chk("R2 load over step", {wrap, addr}, 16'h0555);
    cyc(0, 0, 15'h7777, 0); chk("R5 hold", {wrap, addr}, 16'h0555);
  endtask

  task automatic t_bounds;
    logic [14:0] st [6] = '{15'h0007, 15'h003F, 15'h01FF, 15'h0FFF, 15'h2AAF, 15'h00FE};
    foreach (st[i]) begin
      cyc(0, 1, st[i], 0);
      cyc(1, 0, '0, 0);
      chk("R3/R4 boundary", {1'b0, addr}, {1'b0, st[i] + 15'd1});
      chk("R4 no wrap", {15'b0, wrap}, 16'h0);
    end
  endtask

  task automatic t_wrap_off;
    cyc(0, 1, 15'h7FFF, 0);
    cyc(1, 0, '0, 0);
    chk("R7 rollover no mode", {wrap, addr}, 16'h0000);
  endtask

  task automatic t_sweep;
    logic [14:0] m = 0;
    cyc(0, 1, 15'h0000, 1);
    for (int i = 0; i < 32768; i++) begin
      cyc(1, 0, '0, 1);
      m = m + 15'd1;
      if (i != 32767 && (addr !== m || wrap !== 1'b0))
        chk("R3 sweep", {wrap, addr}, {1'b0, m});
    end
    n_chk++;
    chk("R6 wrap set", {wrap, addr}, 16'h8000);
    cyc(0, 1, 15'h0042, 0); chk("R2 load keeps wrap", {wrap, addr}, 16'h8042);
    cyc(1, 0, '0, 1); chk("R7 no clear", {wrap, addr}, 16'h8043);
    t_reset();
  endtask

  initial begin
    #5;
    t_reset();
    t_load();
    t_bounds();
    t_wrap_off();
    t_sweep();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule